// File: doc/BRIEF.md
# Reset-Time Register Context Loader

This block brings a processor core out of reset without any hard-wired reset vector or register reset values. Once reset is released it walks the register-context image at the bottom of physical memory one slot at a time. Each slot that holds real data is read over a single-word memory read port and written into the core's register file. Slots that a parameter marks as reserved get no memory read; the block writes zero into them instead, so every register ends the load with a defined value.

When the last slot has been written, the block raises a sticky `done`, which means the core now runs in system mode. In the same cycle it gives a one-cycle `fetch_enable` start pulse to the fetch unit. The start address travels on `boot_ip`, which holds the word that was loaded into the program-counter slot (R15 of the context). The fetch unit combines it with the freshly loaded translation and status registers. An asynchronous active-low reset, released synchronously outside the block, aborts a load at any point. The next load then starts again from the first slot.

The context is 128 slots of 16 bits, which is 256 bytes. Slot `i` lives at byte address `2*i`, so the image spans 0x000 to 0x0FE.

Top module: `ctx_boot_loader`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `mem_rd`, `rf_we`, `fetch_enable` and `done` are all 0.
- R2: Every read uses byte address `2*slot`, which keeps bit 0 at 0 and the address within 0x000..0x0FE. The first read after reset is at 0x000 when slot 0 is not reserved.
- R3: Slots are handled in ascending order. A slot whose bit in `RESV_MASK` is 1 is never read, so one load issues exactly as many reads as `RESV_MASK` has zero bits.
- R4: A non-reserved slot `i` is written with `rf_idx = i` and `rf_wdata` equal to the memory word returned for address `2*i`.
- R5: A reserved slot `i` is written with `rf_idx = i` and `rf_wdata = 0`. This write takes one cycle and `mem_rd` is low during it.
- R6: A non-reserved slot is written only in a cycle where `mem_rd` and `mem_ready` are both 1. In any other cycle `mem_rdata` has no effect.
- R7: Only one read is outstanding at a time. While `mem_rd` is high and `mem_ready` is low, `mem_rd` stays high and `mem_addr` stays unchanged in the next cycle.
- R8: `fetch_enable` is high for exactly one cycle, the cycle after the final slot write. `done` rises in that same cycle and stays high until reset.
- R9: When `done` is high, `boot_ip` equals the value written into slot `PC_SLOT` (default 15).
- R10: While `done` is high, `mem_rd` and `rf_we` stay low.
- R11: Dropping `rst_n` at any moment removes `rf_we` and `mem_rd` at once, even during a ready handshake. After release the load starts again from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Byte address of the word being read |
| mem_rd | output | 1 | Read request, held until `mem_ready` |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Read completes in this cycle |
| rf_idx | output | IDX_W | Register-file slot being written |
| rf_wdata | output | DATA_W | Register-file write data |
| rf_we | output | 1 | Register-file write enable |
| fetch_enable | output | 1 | One-cycle start pulse to instruction fetch |
| done | output | 1 | Load complete, core in system mode |
| boot_ip | output | DATA_W | Start address taken from the program-counter slot |

## Verification
The write-back of a returned word and a reset can land in the same cycle. The bench provokes this by raising `mem_ready` with valid data partway through a load and then dropping `rst_n` before the clock edge. It judges the result at the ports: `rf_we` and `mem_rd` must fall immediately, and the load that follows must start again at address 0x000 and complete with a correct image. The bench also lines up a zero-wait ready with the program-counter slot and with the last readable slot. It runs one load with every read answered in the same cycle and others with random wait states, so write-back, start-address capture and the move onto a reserved tail all share cycles with a handshake.

// File: rtl/ctx_boot_pkg.sv
package ctx_boot_pkg;
  // Loader phase: one settle cycle after reset, slot walk, finished.
  typedef enum logic [1:0] {
    LD_START = 2'd0,
    LD_RUN   = 2'd1,
    LD_DONE  = 2'd2
  } ld_state_e;
endpackage

// File: rtl/ctx_slot_seq.sv
// Slot walker: steps through the context slots and decides when a slot is
// finished (reserved slots finish at once, others on the memory handshake).
module ctx_slot_seq
  import ctx_boot_pkg::*;
#(
  parameter int                   NUM_SLOTS = 128,
  parameter int                   IDX_W     = 7,
  parameter logic [NUM_SLOTS-1:0] RESV_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_ready,
  output ld_state_e        state_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             slot_resv,
  output logic             step,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  ld_state_e        state_d;
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    slot_resv = RESV_MASK[idx_q];
    last      = (idx_q == LAST_IDX);
    step      = (state_q == LD_RUN) && (slot_resv || mem_ready);
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    case (state_q)
      LD_START: state_d = LD_RUN;
      LD_RUN: begin
        if (step) begin
          if (last) begin
            state_d = LD_DONE;
          end else begin
            idx_en = 1'b1;
            idx_d  = idx_q + 1'b1;
          end
        end
      end
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_START;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/ctx_mem_port.sv
// Memory side and register-file data path (purely combinational).
module ctx_mem_port #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 7
) (
  input  logic              run,
  input  logic              slot_resv,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] rf_wdata
);
  always_comb begin
    mem_rd   = run && !slot_resv;
    mem_addr = ADDR_W'({idx, 1'b0});
    rf_wdata = slot_resv ? '0 : mem_rdata;
  end
endmodule

// File: rtl/ctx_handoff.sv
// Completion flag, start pulse and captured start address.
module ctx_handoff #(
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 7,
  parameter int PC_SLOT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              last,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              done_q,
  output logic              fetch_q,
  output logic [DATA_W-1:0] ip_q
);
  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(PC_SLOT);

  logic              done_d;
  logic              fetch_d;
  logic [DATA_W-1:0] ip_d;
  logic              ip_en;

  always_comb begin
    done_d  = done_q;
    fetch_d = 1'b0;
    ip_en   = step && (idx == PC_IDX);
    ip_d    = wdata;
    if (step && last) begin
      done_d  = 1'b1;
      fetch_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fetch_q <= 1'b0;
      ip_q    <= '0;
    end else begin
      done_q  <= done_d;
      fetch_q <= fetch_d;
      if (ip_en) ip_q <= ip_d;
    end
  end
endmodule

// File: rtl/ctx_boot_loader.sv
module ctx_boot_loader
  import ctx_boot_pkg::*;
#(
  parameter int                   NUM_SLOTS = 128,
  parameter int                   DATA_W    = 16,
  parameter int                   ADDR_W    = 16,
  parameter int                   PC_SLOT   = 15,
  parameter logic [NUM_SLOTS-1:0] RESV_MASK = 128'hFF00_0000_0000_0000_0000_0000_000F_0000,
  localparam int                  IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              fetch_enable,
  output logic              done,
  output logic [DATA_W-1:0] boot_ip
);
  ld_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             slot_resv;
  logic             step;
  logic             last;

  ctx_slot_seq #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W),
    .RESV_MASK (RESV_MASK)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ready (mem_ready),
    .state_q   (state_q),
    .idx_q     (idx_q),
    .slot_resv (slot_resv),
    .step      (step),
    .last      (last)
  );

  ctx_mem_port #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_port (
    .run       (state_q == LD_RUN),
    .slot_resv (slot_resv),
    .idx       (idx_q),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .rf_wdata  (rf_wdata)
  );

  ctx_handoff #(
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .PC_SLOT (PC_SLOT)
  ) u_hand (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .last    (last),
    .idx     (idx_q),
    .wdata   (rf_wdata),
    .done_q  (done),
    .fetch_q (fetch_enable),
    .ip_q    (boot_ip)
  );

  assign rf_we  = step;
  assign rf_idx = idx_q;
endmodule

// File: rtl/ctx_boot_loader_chk.sv
module ctx_boot_loader_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_ready,
  input logic              rf_we,
  input logic              fetch_enable,
  input logic              done
);
  // R2: aligned and inside the image
  p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[0] == 1'b0 && mem_addr <= ADDR_W'(16'h00FE)));

  // R6: a write during a read only on the handshake
  p_write_on_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && mem_rd) |-> mem_ready);

  // R7: request and address held while waiting
  p_hold_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  // R8: single-cycle start pulse
  p_fetch_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_enable |=> !fetch_enable);

  // R8: pulse only together with completion
  p_fetch_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_enable |-> done);

  // R8: completion is sticky
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R8: first cycle of done carries the pulse
  p_done_rise_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> fetch_enable);

  // R10: quiet after completion
  p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_rd && !rf_we));
endmodule

bind ctx_boot_loader ctx_boot_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_addr     (mem_addr),
  .mem_rd       (mem_rd),
  .mem_ready    (mem_ready),
  .rf_we        (rf_we),
  .fetch_enable (fetch_enable),
  .done         (done)
);

// File: tb/ctx_boot_loader_bench.sv
`timescale 1ns/1ps
module ctx_boot_loader_bench;
  localparam int          NS   = 128;
  localparam int          DW   = 16;
  localparam int          AW   = 16;
  localparam int          PCS  = 15;
  localparam logic [127:0] MASK = 128'hFF00_0000_0000_0000_0000_0000_000F_0000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [DW-1:0] mem_rdata;
  logic          mem_ready;
  logic [6:0]    rf_idx;
  logic [DW-1:0] rf_wdata;
  logic          rf_we;
  logic          fetch_enable;
  logic          done;
  logic [DW-1:0] boot_ip;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  ctx_boot_loader #(
    .NUM_SLOTS (NS), .DATA_W (DW), .ADDR_W (AW), .PC_SLOT (PCS), .RESV_MASK (MASK)
  ) u_ctx_boot_loader (
    .clk (clk), .rst_n (rst_n), .mem_addr (mem_addr), .mem_rd (mem_rd),
    .mem_rdata (mem_rdata), .mem_ready (mem_ready), .rf_idx (rf_idx),
    .rf_wdata (rf_wdata), .rf_we (rf_we), .fetch_enable (fetch_enable),
    .done (done), .boot_ip (boot_ip)
  );

  function automatic logic [DW-1:0] img_word(int run, int slot);
    return DW'(slot * 499 + run * 7919) ^ 16'hC35A;
  endfunction

  function automatic int readable_count();
    int c = 0;
    for (int i = 0; i < NS; i++) if (!MASK[i]) c++;
    return c;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mem_ready = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    check(!mem_rd && !rf_we && !done && !fetch_enable, "R1 idle in reset",
          {mem_rd, rf_we, done, fetch_enable}, 0);
    rst_n = 1'b1;
    #1;
    check(!mem_rd && !rf_we, "R1 idle after release", {mem_rd, rf_we}, 0);
  endtask

  // One full load; max_wait 0 answers every read in its own cycle.
  task automatic do_load(int run, int max_wait);
    logic [DW-1:0] shadow [NS];
    bit   wr_seen [NS];
    int   cyc = 0, waitc, reads = 0, last_slot = -1, first_addr = -1;
    int   last_wr = -1, fetch_cyc = -1, fetch_cnt = 0, after_done = 0;
    int   done_cyc = -1;
    bit   pending = 0, bad_order = 0, bad_hold = 0, bad_resv_rd = 0;
    bit   bad_wr = 0, bad_sticky = 0, bad_quiet = 0, seen_done = 0;
    logic [AW-1:0] held = '0;
    for (int i = 0; i < NS; i++) begin shadow[i] = 16'hDEAD; wr_seen[i] = 0; end
    waitc = $urandom_range(max_wait, 0);
    do_reset();
    while (cyc < 3000 && after_done < 5) begin
      @(negedge clk);
      cyc++;
      if (mem_rd && waitc == 0) begin
        mem_ready = 1'b1;
        mem_rdata = img_word(run, int'(mem_addr >> 1));
        waitc     = $urandom_range(max_wait, 0);
      end else begin
        mem_ready = 1'b0;
        mem_rdata = DW'($urandom);      // garbage must be ignored (R6)
        if (mem_rd) waitc--;
      end
      #2;
      if (mem_rd) begin
        int s = int'(mem_addr >> 1);
        if (first_addr < 0) first_addr = int'(mem_addr);
        if (mem_addr[0] || mem_addr > 16'h00FE) bad_order = 1;
        if (MASK[s]) bad_resv_rd = 1;
        if (pending) begin
          if (mem_addr != held) bad_hold = 1;
        end else begin
          if (s <= last_slot) bad_order = 1;
          last_slot = s;
        end
        pending = !mem_ready;
        held    = mem_addr;
        if (mem_ready) reads++;
      end else if (pending) begin
        bad_hold = 1;
        pending  = 0;
      end
      if (rf_we) begin
        int s = int'(rf_idx);
        if (MASK[s]) begin
          if (mem_rd || rf_wdata != '0) bad_wr = 1;
        end else begin
          if (!(mem_rd && mem_ready)) bad_wr = 1;
        end
        shadow[s]  = rf_wdata;
        wr_seen[s] = 1;
        last_wr    = cyc;
      end
      if (fetch_enable) begin fetch_cnt++; fetch_cyc = cyc; end
      if (seen_done) begin
        after_done++;
        if (!done) bad_sticky = 1;
        if (mem_rd || rf_we) bad_quiet = 1;
      end else if (done) begin
        seen_done = 1;
        done_cyc  = cyc;
      end
    end
    mem_ready = 1'b0;
    check(seen_done, "R8 load completes", seen_done, 1);
    check(first_addr == 0, "R2 first read address", first_addr, 0);
    check(!bad_order && !bad_resv_rd && reads == readable_count(),
          "R3 ascending reads skip reserved", reads, readable_count());
    begin
      int bad4 = 0, bad5 = 0;
      for (int i = 0; i < NS; i++) begin
        if (!MASK[i] && (!wr_seen[i] || shadow[i] != img_word(run, i))) bad4++;
        if ( MASK[i] && (!wr_seen[i] || shadow[i] != '0)) bad5++;
      end
      check(bad4 == 0, "R4 loaded words", bad4, 0);
      check(bad5 == 0, "R5 reserved slots zero", bad5, 0);
    end
    check(!bad_wr, "R6 write only on handshake", bad_wr, 0);
    check(!bad_hold, "R7 request held while waiting", bad_hold, 0);
    check(fetch_cnt == 1 && fetch_cyc == last_wr + 1 && done_cyc == fetch_cyc && !bad_sticky,
          "R8 start pulse and sticky done", fetch_cyc, last_wr + 1);
    check(boot_ip == img_word(run, PCS), "R9 start address", boot_ip, img_word(run, PCS));
    check(!bad_quiet, "R10 quiet after done", bad_quiet, 0);
  endtask

  // Reset lands in the cycle of a ready handshake.
  task automatic abort_mid_load();
    int writes = 0;
    do_reset();
    for (int c = 0; c < 400 && writes < 21; c++) begin
      @(negedge clk);
      mem_ready = mem_rd;
      mem_rdata = img_word(9, int'(mem_addr >> 1));
      #2;
      if (rf_we) writes++;
    end
    @(negedge clk);
    mem_ready = 1'b1;
    mem_rdata = 16'hBEEF;
    #1;
    check(mem_rd && rf_we, "R11 handshake pending before abort", {mem_rd, rf_we}, 3);
    rst_n = 1'b0;
    #1;
    check(!rf_we && !mem_rd && !done, "R11 abort removes write", {rf_we, mem_rd, done}, 0);
    mem_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240613));
    rst_n = 1'b0;
    mem_ready = 1'b0;
    mem_rdata = '0;
    do_load(0, 0);
    do_load(1, 3);
    do_load(2, 1);
    do_load(3, 5);
    abort_mid_load();
    do_load(4, 2);                    // R11 restart from slot 0 after abort
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule